// File: doc/BRIEF.md
# I/Q DAC Test-Access Register Bank

This block gives a host direct byte-level access to the in-phase and quadrature samples that feed a pair of DACs, so the modulator and interpolation filter can be skipped during test or in systems that do not need them. Each channel's sample is split into a low byte and a high byte, and every byte has its own address. Host writes land in staging registers. On the next pulse of the internal sample strobe, all staged bytes are copied together into the committed sample register that drives the DACs.

The host can have the sample strobe exported on one of two pins, which lets it time its writes so that the bytes of one sample are not split across two strobes. The block does not guard against such a split. Readback returns the committed bytes. When bypass is off, the DAC outputs pass the normal filter-path samples through unchanged.

Top module: `iq_test_port`

## Requirements
- R1: After reset, all staging and committed bytes are zero, the route field is 00, both strobe pins are low, and with bypass on both DAC outputs read zero.
- R2: A write to byte address 0 (I low), 1 (I high), 2 (Q low) or 3 (Q high) changes only the staged byte. The DAC outputs keep their values until a sample strobe arrives.
- R3: On a cycle in which the sample strobe is high, all four staged bytes are committed together. The DAC outputs show the new sample from the next cycle, with I = {byte1, byte0} and Q = {byte3, byte2}.
- R4: A write made in the same cycle as a strobe is not part of that commit and joins the following sample. Writes that straddle a strobe therefore produce a sample that mixes old and new bytes.
- R5: While the strobe is low, the committed sample does not change.
- R6: With bypass low, the I and Q DAC outputs equal the filter-path inputs. With bypass high, they equal the committed sample.
- R7: A read of addresses 0 to 3 returns the committed byte, never the staged byte. A read of address 4 returns the route field in bits 1:0, with all other bits zero.
- R8: A write to address 4 loads the route field from data bits 1:0. Value 01 copies the strobe onto pin A in the same cycle, 10 copies it onto pin B, and 00 or 11 leaves both pins low.
- R9: Writes to addresses 5 to 7 change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read data |
| smp_stb | input | 1 | Internal sample strobe, one cycle per sample |
| bypass_en | input | 1 | Selects the committed register (1) or the filter path (0) for the DACs |
| fil_i | input | 16 | Filter-path I sample |
| fil_q | input | 16 | Filter-path Q sample |
| dac_i | output | 16 | I sample to DAC |
| dac_q | output | 16 | Q sample to DAC |
| stb_pin_a | output | 1 | Strobe copy on export pin A |
| stb_pin_b | output | 1 | Strobe copy on export pin B |

## Verification
A host byte write and a sample strobe can fall in the same cycle. The bench creates this case deliberately by asserting wr_en and smp_stb together, both on a single byte and in the middle of a four-byte update. The judgement is that the commit takes the previously staged byte and the new byte appears only after the following strobe, which leaves a mixed sample when the writes straddle a strobe. A behavioural model updated with the same ordering supplies the expected DAC, readback and pin values on every cycle.

// File: rtl/iq_tap_pkg.sv
package iq_tap_pkg;
  typedef enum logic [1:0] {
    RT_OFF   = 2'b00,
    RT_PIN_A = 2'b01,
    RT_PIN_B = 2'b10,
    RT_RSVD  = 2'b11
  } route_e;
endpackage

// File: rtl/iq_stage_bank.sv
module iq_stage_bank #(
  parameter int BYTE_W = 8,
  parameter int NSLOT  = 4,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic [NSLOT-1:0][BYTE_W-1:0]  stage
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic              hit;
    logic [BYTE_W-1:0] nxt;

    assign hit = wr_en && (addr == ADDR_W'(g));

    always_comb begin
      nxt = stage[g];
      if (hit) nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= '0;
      else        stage[g] <= nxt;
    end

    // R2
    stage_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(g)) |=> stage[g] == $past(wr_data));
  end
endmodule

// File: rtl/iq_commit_reg.sv
module iq_commit_reg #(
  parameter int BYTE_W = 8,
  parameter int NSLOT  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          smp_stb,
  input  logic [NSLOT-1:0][BYTE_W-1:0]  stage,
  output logic [NSLOT-1:0][BYTE_W-1:0]  held
);
  logic [NSLOT-1:0][BYTE_W-1:0] held_nxt;

  always_comb begin
    held_nxt = held;
    if (smp_stb) held_nxt = stage;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= held_nxt;
  end

  // R3
  commit_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> held == $past(stage));

  // R5
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(held));
endmodule

// File: rtl/iq_strobe_route.sv
module iq_strobe_route
  import iq_tap_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int ROUTE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wr_bits,
  input  logic              smp_stb,
  output logic [1:0]        route,
  output logic              pin_a,
  output logic              pin_b
);
  logic [1:0] route_nxt;

  always_comb begin
    route_nxt = route;
    if (wr_en && addr == ADDR_W'(ROUTE_ADDR)) route_nxt = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route <= RT_OFF;
    else        route <= route_nxt;
  end

  assign pin_a = smp_stb && (route == RT_PIN_A);
  assign pin_b = smp_stb && (route == RT_PIN_B);

  // R8
  pins_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_a && pin_b));

  // R8
  pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_a || pin_b) |-> smp_stb);
endmodule

// File: rtl/iq_test_port.sv
module iq_test_port #(
  parameter int BYTE_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                smp_stb,
  input  logic                bypass_en,
  input  logic [SAMPLE_W-1:0] fil_i,
  input  logic [SAMPLE_W-1:0] fil_q,
  output logic [SAMPLE_W-1:0] dac_i,
  output logic [SAMPLE_W-1:0] dac_q,
  output logic                stb_pin_a,
  output logic                stb_pin_b
);
  localparam int BYTES      = SAMPLE_W / BYTE_W;
  localparam int NSLOT      = 2 * BYTES;
  localparam int ROUTE_ADDR = NSLOT;

  logic [NSLOT-1:0][BYTE_W-1:0] stage;
  logic [NSLOT-1:0][BYTE_W-1:0] held;
  logic [1:0]                   route;

  iq_stage_bank #(.BYTE_W(BYTE_W), .NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .stage(stage)
  );

  iq_commit_reg #(.BYTE_W(BYTE_W), .NSLOT(NSLOT)) u_commit (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .stage(stage), .held(held)
  );

  iq_strobe_route #(.ADDR_W(ADDR_W), .ROUTE_ADDR(ROUTE_ADDR)) u_route (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_bits(wr_data[1:0]), .smp_stb(smp_stb), .route(route),
    .pin_a(stb_pin_a), .pin_b(stb_pin_b)
  );

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (addr == ADDR_W'(k)) rd_data = held[k];
    end
    if (addr == ADDR_W'(ROUTE_ADDR)) rd_data = BYTE_W'(route);
  end

  assign dac_i = bypass_en ? held[BYTES-1:0]     : fil_i;
  assign dac_q = bypass_en ? held[NSLOT-1:BYTES] : fil_q;

  // R6
  dac_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && !$past(smp_stb)) |-> $stable(dac_i) || !$past(bypass_en));
endmodule

// File: tb/iq_test_port_test.sv
`timescale 1ns/1ps
module iq_test_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, smp_stb, bypass_en;
  logic [2:0]  addr;
  logic [7:0]  wr_data, rd_data;
  logic [15:0] fil_i, fil_q, dac_i, dac_q;
  logic        stb_pin_a, stb_pin_b;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int m_stage[4];
  int m_held[4];
  int m_route;

  always #2.5 clk = ~clk;

  iq_test_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .smp_stb(smp_stb), .bypass_en(bypass_en),
    .fil_i(fil_i), .fil_q(fil_q), .dac_i(dac_i), .dac_q(dac_q),
    .stb_pin_a(stb_pin_a), .stb_pin_b(stb_pin_b)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int ei, eq, er;
    ei = bypass_en ? (m_held[1] * 256 + m_held[0]) : int'(fil_i);
    eq = bypass_en ? (m_held[3] * 256 + m_held[2]) : int'(fil_q);
    if (addr < 4)       er = m_held[addr];
    else if (addr == 4) er = m_route;
    else                er = 0;
    cmp(tag, "dac_i", int'(dac_i), ei);
    cmp(tag, "dac_q", int'(dac_q), eq);
    cmp(tag, "rd_data", int'(rd_data), er);
    cmp(tag, "pin_a", int'(stb_pin_a), int'(smp_stb && m_route == 1));
    cmp(tag, "pin_b", int'(stb_pin_b), int'(smp_stb && m_route == 2));
  endtask

  // drive inputs, check outputs before the edge, then advance the model
  task automatic step(input bit we, input int a, input int d, input bit stb,
                      input bit byp, input string tag);
    wr_en = we; addr = 3'(a); wr_data = 8'(d); smp_stb = stb; bypass_en = byp;
    #1;
    compare_all(tag);
    @(posedge clk);
    if (stb) for (int k = 0; k < 4; k++) m_held[k] = m_stage[k];
    if (we) begin
      if (a < 4)       m_stage[a] = d;
      else if (a == 4) m_route = d % 4;
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_stage[k] = 0; m_held[k] = 0; end
    m_route = 0;
    rst_n = 1'b0; wr_en = 0; addr = 0; wr_data = 0; smp_stb = 0; bypass_en = 1;
    fil_i = 16'h1234; fil_q = 16'hABCD;
    repeat (3) @(negedge clk);
    #1; compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 4, 0, 1, 1, "R1");

    // R2: staged writes leave outputs and readback alone
    step(1, 0, 8'h11, 0, 1, "R2");
    step(1, 1, 8'h22, 0, 1, "R2");
    step(1, 2, 8'h33, 0, 1, "R2");
    step(1, 3, 8'h44, 0, 1, "R7");
    for (int a = 0; a < 4; a++) step(0, a, 0, 0, 1, "R7");
    // R3: commit all four at once
    step(0, 0, 0, 1, 1, "R3");
    for (int a = 0; a < 4; a++) step(0, a, 0, 0, 1, "R3");
    // R4: write coinciding with strobe joins the next sample
    step(1, 0, 8'hA5, 1, 1, "R4");
    step(0, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, 1, "R4");
    step(0, 0, 0, 0, 1, "R4");
    // R4: four-byte update straddling a strobe
    step(1, 0, 8'h01, 0, 1, "R4");
    step(1, 1, 8'h02, 0, 1, "R4");
    step(1, 2, 8'h03, 1, 1, "R4");
    step(1, 3, 8'h04, 0, 1, "R4");
    for (int a = 0; a < 4; a++) step(0, a, 0, 0, 1, "R4");
    // R5: no strobe, no change
    for (int n = 0; n < 6; n++) step(0, n % 4, 0, 0, 1, "R5");
    // R6: bypass off passes filter path
    fil_i = 16'h5A5A; fil_q = 16'hC3C3;
    step(0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");
    fil_i = 16'h0F0F; fil_q = 16'hF0F0;
    step(0, 1, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 1, "R6");
    // R8: route values
    for (int r = 0; r < 4; r++) begin
      step(1, 4, 8'hFC | r, 0, 1, "R8");
      step(0, 4, 0, 1, 1, "R8");
      step(0, 4, 0, 0, 1, "R8");
    end
    step(1, 4, 1, 0, 1, "R8");
    step(0, 2, 0, 1, 1, "R8");
    // R9: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      step(1, a, 8'hFF, 0, 1, "R9");
      step(0, a, 0, 1, 1, "R9");
    end
    for (int a = 0; a < 5; a++) step(0, a, 0, 0, 1, "R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule